// File: doc/BRIEF.md
# Dual chip-select wait state generator

This block sits beside a CPU on a 20-bit memory bus. It decodes each memory address into one of two active-low chip selects: a ROM select for every address under a programmable ROM limit, and a RAM select for addresses inside a programmable RAM window. If the two ranges overlap, the ROM select wins.

Each chip select has its own 3-bit wait count, held in a small control register together with an enable bit. When a qualifying memory access begins, the block loads a wait counter. The value loaded is the larger of two counts: the count of the selected chip, and the wait count that the CPU's own wait logic supplies. The wait output then stays active until the counter reaches zero. Transfers driven by a DMA engine are plain memory accesses on the same strobes, so they receive the same waits. The chip-select counts are ignored for the very first memory access after reset. That access runs with the CPU count alone, so boot code can fetch from slow memory before software has programmed the counts.

Top module: `cs_wait_gen`

## Requirements
- R1: After reset the control register is 0 (feature disabled), the ROM limit is 0x10000, and both RAM window bounds are 0xFFFFF, so the RAM window is empty.
- R2: `rom_cs_no` is low while `mreq_i` is high and `addr_i` is below the ROM limit.
- R3: `ram_cs_no` is low while `mreq_i` is high, `addr_i` is at least the RAM lower bound and below the RAM upper bound, and the address is not a ROM address.
- R4: When an address falls in both the ROM range and the RAM window, only `rom_cs_no` goes low.
- R5: With `mreq_i` low, both chip selects stay high whatever the address.
- R6: A register is written on a clock edge with `cfg_we_i` high. `cfg_sel_i` picks the register: 0 is the control register, 1 the ROM limit, 2 the RAM lower bound, 3 the RAM upper bound. Control register fields: bit 0 is enable, bits 3:1 are the ROM wait count, bits 6:4 are the RAM wait count.
- R7: An access qualifies when `mreq_i` is high and either `rd_i` or `wr_i` is high. On the first clock edge of a qualifying access the counter loads N. `wait_o` is then high for exactly N cycles and low afterwards while the access is held.
- R8: N is the larger of `cpu_wait_i` and the chip-select count. The chip-select count is the ROM field for a ROM access and the RAM field for a RAM access. It is 0 when no chip select is active or the enable bit is 0.
- R9: For the first qualifying access after reset, the chip-select count is taken as 0, so N equals `cpu_wait_i`.
- R10: When the access ends (it stops qualifying), the counter clears and `wait_o` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 20 | Memory address |
| mreq_i | input | 1 | Memory request, active high |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| cpu_wait_i | input | 3 | Wait count from the CPU's own wait logic |
| cfg_we_i | input | 1 | Register write enable |
| cfg_sel_i | input | 2 | Register select |
| cfg_wdata_i | input | 20 | Register write data |
| rom_cs_no | output | 1 | ROM chip select, active low |
| ram_cs_no | output | 1 | RAM chip select, active low |
| wait_o | output | 1 | Wait request to the CPU |

## Verification
The hardest case to reach is the first-access rule. Only one access after each reset sees the chip-select counts suppressed, and that happens only if the counts were already programmed. The bench therefore writes a nonzero ROM count and a smaller CPU count before any access. It checks that the first ROM access waits only the CPU count and that the identical second access waits the ROM count. The overlap priority is reached by moving the ROM limit into the RAM window. A truncated access is reached by dropping `mreq_i` partway through a long wait.

// File: rtl/cs_wait_pkg.sv
package cs_wait_pkg;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned WAIT_W = 3;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_ROM_LIM = 2'd1,
    SEL_RAM_LO = 2'd2,
    SEL_RAM_HI = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [WAIT_W-1:0] ram_wait;
    logic [WAIT_W-1:0] rom_wait;
    logic              en;
  } ctrl_t;
endpackage

// File: rtl/cs_regs.sv
module cs_regs
  import cs_wait_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ROM_LIM_RST = 20'h10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [ADDR_W-1:0] rom_lim_o,
  output logic [ADDR_W-1:0] ram_lo_o,
  output logic [ADDR_W-1:0] ram_hi_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o    <= '0;
      rom_lim_o <= ROM_LIM_RST;
      ram_lo_o  <= '1;
      ram_hi_o  <= '1;
    end else if (we_i) begin
      unique case (cfg_sel_e'(sel_i))
        SEL_CTRL:    ctrl_o    <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        SEL_ROM_LIM: rom_lim_o <= wdata_i;
        SEL_RAM_LO:  ram_lo_o  <= wdata_i;
        SEL_RAM_HI:  ram_hi_o  <= wdata_i;
        default: ;
      endcase
    end
  end

  // R6: write lands in the selected register
  a_r6_hi_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd3) |=> (ram_hi_o == $past(wdata_i)));
  a_r6_rom_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd1) |=> (rom_lim_o == $past(wdata_i)));
endmodule

// File: rtl/cs_decode.sv
module cs_decode
  import cs_wait_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] rom_lim_i,
  input  logic [ADDR_W-1:0] ram_lo_i,
  input  logic [ADDR_W-1:0] ram_hi_i,
  output logic              rom_hit_o,
  output logic              ram_hit_o
);
  logic in_rom, in_ram;

  always_comb begin
    in_rom    = addr_i < rom_lim_i;
    in_ram    = (addr_i >= ram_lo_i) && (addr_i < ram_hi_i);
    rom_hit_o = in_rom;
    ram_hit_o = in_ram && !in_rom;  // ROM has priority on overlap
  end

  // R4: decoder never reports both
  always_comb a_r4_one_hit: assert (!(rom_hit_o && ram_hit_o));
endmodule

// File: rtl/wait_ctr.sv
module wait_ctr
  import cs_wait_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] load_i,
  output logic              wait_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!active_i)       cnt_q <= '0;
    else if (start_i)         cnt_q <= load_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign wait_o = (cnt_q != '0);

  // R7: count runs down by one per cycle during a held access
  a_r7_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R10: ending the access drops the wait
  a_r10_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !wait_o);
endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen
  import cs_wait_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ROM_LIM_RST = 20'h10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mreq_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [WAIT_W-1:0] cpu_wait_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  output logic              rom_cs_no,
  output logic              ram_cs_no,
  output logic              wait_o
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] rom_lim, ram_lo, ram_hi;
  logic              rom_hit, ram_hit;
  logic              active, active_q, start, first_done_q;
  logic [WAIT_W-1:0] cs_wait, load_val;

  cs_regs #(.ROM_LIM_RST(ROM_LIM_RST)) u_regs (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .ctrl_o(ctrl), .rom_lim_o(rom_lim), .ram_lo_o(ram_lo), .ram_hi_o(ram_hi)
  );

  cs_decode u_dec (
    .addr_i, .rom_lim_i(rom_lim), .ram_lo_i(ram_lo), .ram_hi_i(ram_hi),
    .rom_hit_o(rom_hit), .ram_hit_o(ram_hit)
  );

  assign rom_cs_no = !(mreq_i && rom_hit);
  assign ram_cs_no = !(mreq_i && ram_hit);

  assign active = mreq_i && (rd_i || wr_i);
  assign start  = active && !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q     <= 1'b0;
      first_done_q <= 1'b0;
    end else begin
      active_q <= active;
      if (start) first_done_q <= 1'b1;
    end
  end

  always_comb begin
    cs_wait = '0;
    if (ctrl.en && first_done_q) begin
      if (rom_hit)      cs_wait = ctrl.rom_wait;
      else if (ram_hit) cs_wait = ctrl.ram_wait;
    end
    load_val = (cs_wait > cpu_wait_i) ? cs_wait : cpu_wait_i;
  end

  wait_ctr u_ctr (
    .clk_i, .rst_ni, .active_i(active), .start_i(start), .load_i(load_val),
    .wait_o
  );

  // R4: chip selects never both active
  a_r4_cs_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rom_cs_no && !ram_cs_no));
  // R5: no select without a request
  a_r5_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mreq_i |-> (rom_cs_no && ram_cs_no));
  // R8: CPU wait is a floor on the inserted wait
  a_r8_cpu_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && cpu_wait_i != '0) |=> wait_o);
  // R9: first access waits only the CPU count
  a_r9_first_cpu_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !first_done_q && cpu_wait_i == '0) |=> !wait_o);
endmodule

// File: tb/cs_wait_gen_tb_top.sv
module cs_wait_gen_tb_top;
  localparam int NV = 8;
  localparam logic [19:0] V_ADDR [NV] = '{20'h00100, 20'h00100, 20'h40000, 20'h7FFFF,
                                          20'h80000, 20'h3FFFF, 20'h0FFFF, 20'h10000};
  localparam logic [2:0]  V_CPU  [NV] = '{3'd1, 3'd7, 3'd0, 3'd2, 3'd2, 3'd0, 3'd0, 3'd4};
  localparam logic        V_ROM  [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic        V_RAM  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam int          V_WAIT [NV] = '{5, 7, 3, 3, 2, 0, 5, 4};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic mreq = 0, rd = 0, wr = 0, we = 0;
  logic [2:0] cpu_wait = '0;
  logic [1:0] sel = '0;
  logic [19:0] wdata = '0;
  logic rom_cs_n, ram_cs_n, wt;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  cs_wait_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .mreq_i(mreq), .rd_i(rd), .wr_i(wr),
    .cpu_wait_i(cpu_wait), .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wdata),
    .rom_cs_no(rom_cs_n), .ram_cs_no(ram_cs_n), .wait_o(wt)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [19:0] d);
    @(negedge clk); we = 1; sel = s; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic cs_check(input string req, input logic [19:0] a, input logic r, input logic m);
    @(negedge clk); addr = a; mreq = 1; #1;
    chk({req, " rom_cs"}, int'(!rom_cs_n), int'(r));
    chk({req, " ram_cs"}, int'(!ram_cs_n), int'(m));
    mreq = 0;
  endtask

  // access: returns number of cycles wait_o was high
  task automatic access(input logic [19:0] a, input logic [2:0] c, input logic is_rd,
                        output int n, output logic r, output logic m);
    @(negedge clk); addr = a; cpu_wait = c; mreq = 1; rd = is_rd; wr = !is_rd; #1;
    r = !rom_cs_n; m = !ram_cs_n; n = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (wt) n++; else break;
    end
    mreq = 0; rd = 0; wr = 0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n; logic r, m;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1/R2 reset decode
    @(negedge clk); #1;
    chk("R1 wait idle", int'(wt), 0);
    cs_check("R1 R2 below reset limit", 20'h00100, 1, 0);
    cs_check("R1 at reset limit", 20'h10000, 0, 0);
    cs_check("R1 empty ram window", 20'hFFFFF, 0, 0);
    // R6 program: en=1, rom=5, ram=3 -> 0x3B
    wr_reg(2'd0, 20'h0003B);
    wr_reg(2'd2, 20'h40000);
    wr_reg(2'd3, 20'h80000);
    // R9 first access uses CPU count only
    access(20'h00100, 3'd1, 1'b1, n, r, m);
    chk("R9 first access wait", n, 1);
    // R7 R8 R2 R3 vector walk
    for (int i = 0; i < NV; i++) begin
      access(V_ADDR[i], V_CPU[i], i[0], n, r, m);
      chk($sformatf("R2 vec%0d rom_cs", i), int'(r), int'(V_ROM[i]));
      chk($sformatf("R3 vec%0d ram_cs", i), int'(m), int'(V_RAM[i]));
      chk($sformatf("R7 R8 vec%0d wait", i), n, V_WAIT[i]);
    end
    // R4 overlap: move ROM limit into RAM window
    wr_reg(2'd1, 20'h50000);
    access(20'h45000, 3'd0, 1'b0, n, r, m);
    chk("R4 overlap rom", int'(r), 1);
    chk("R4 overlap ram suppressed", int'(m), 0);
    chk("R4 overlap wait uses rom", n, 5);
    // R5 no request
    @(negedge clk); addr = 20'h00100; mreq = 0; rd = 1; #1;
    chk("R5 rom idle", int'(!rom_cs_n), 0);
    @(negedge clk); addr = 20'h60000; #1;
    chk("R5 ram idle", int'(!ram_cs_n), 0);
    chk("R5 no wait", int'(wt), 0);
    rd = 0;
    // R8 disabled: en=0 keeps counts
    wr_reg(2'd0, 20'h0003A);
    access(20'h00100, 3'd1, 1'b1, n, r, m);
    chk("R8 disabled wait", n, 1);
    // R6 ram field read back through wait: en=1 rom=0 ram=6 -> 0x61
    wr_reg(2'd0, 20'h00061);
    access(20'h60000, 3'd0, 1'b1, n, r, m);
    chk("R6 ram field wait", n, 6);
    access(20'h00100, 3'd2, 1'b0, n, r, m);
    chk("R6 rom field zero", n, 2);
    // R10 truncated access
    @(negedge clk); addr = 20'h60000; cpu_wait = 0; mreq = 1; rd = 1;
    @(negedge clk); #1; chk("R10 wait active", int'(wt), 1);
    @(negedge clk); mreq = 0; rd = 0;
    @(negedge clk); #1; chk("R10 cleared", int'(wt), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule